// File: doc/BRIEF.md
# Video Processor Host Register Interface

This block is the register file that a host processor sees on a tile-based video processor. The host performs single-byte reads and writes through a three-bit register select. The block keeps the display control byte, the render mask byte, the status flags, the sprite memory pointer, the two scroll bytes and the video memory pointer. It also keeps one first/second write toggle, which the scroll and pointer registers share. It drives simple request ports toward a 256-byte sprite attribute memory and a 14-bit-addressed video memory. Both memories are assumed to return read data in the same cycle as the address.

The decoded control and mask fields, the effective scroll position and the interrupt line are outputs for the rendering logic. A frame-timing unit supplies the vertical-blank set and clear strobes, the two sprite status flags and the current dot within the line. The block uses the dot value to park the sprite pointer at zero during a fixed span of each line.

Host read data is registered. The byte for a read issued in one cycle appears on `rdData` after the next rising edge and holds until the next read. When `wrEn` and `rdEn` are both high, the write is taken and the read is dropped.

Top module: `vpu_regif`

## Requirements
- R1: After reset, `rdData`, `sprAddr`, `vidAddr`, `scrollX`, `scrollY` and `irq` are all zero, and so are every decoded control and mask field.
- R2: A write to select 0 stores the control byte. Bits 1:0 are the base nametable and bit 2 is the pointer step (0 = step 1, 1 = step 32). Bit 3 drives `sprTableSel`, bit 4 `bgTableSel`, bit 5 `tallSprites`, bit 6 `extMaster`, and bit 7 enables the interrupt.
- R3: A write to select 1 stores the mask byte. Bit 0 drives `grayscale`, bit 1 `bgLeftShow`, bit 2 `sprLeftShow`, bit 3 `bgShow`, bit 4 `sprShow`, and bits 7:5 drive `emphasis`.
- R4: A read of select 2 returns the vertical-blank flag in bit 7, `sprZeroHit` in bit 6 and `sprOverflow` in bit 5, with the other bits zero. The read clears the vertical-blank flag unless `vblankSet` is high in that cycle.
- R5: A read of select 2 returns the shared write toggle to its first-write state.
- R6: A write to select 5 loads the X scroll byte when the toggle is in its first-write state and the Y scroll byte otherwise. Each such write flips the toggle.
- R7: `scrollX` equals the X byte plus 256 when nametable bit 0 is set. `scrollY` equals the Y byte plus 240 when nametable bit 1 is set.
- R8: A first write to select 6 sets the video pointer to the byte shifted left by eight and masked to 14 bits. A second write ORs the byte into the pointer. Each write flips the toggle.
- R9: A write to select 7 presents the byte on the video write port at the current pointer. The pointer then advances by the step from R2 and wraps within 14 bits.
- R10: A read of select 7 returns the byte held in the read buffer, which is zero after reset. It then loads the buffer from video memory at the current pointer and advances the pointer as in R9.
- R11: A write to select 3 loads the sprite pointer. A write to select 4 stores the byte at the pointer and then adds one to it. A read of select 4 returns the memory byte and leaves the pointer unchanged.
- R12: In any cycle where `dotCount` is greater than 256 and at most 320, the next edge sets the sprite pointer to zero, overriding host writes.
- R13: `irq` is high exactly while the vertical-blank flag and the interrupt enable bit are both set. Enabling the interrupt while the flag is already set raises `irq` right after that write.
- R14: A write to select 2 changes nothing. A read of select 0, 1, 3, 5 or 6 returns zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| regSel | input | 3 | Host register select |
| wrEn | input | 1 | Host write strobe |
| rdEn | input | 1 | Host read strobe |
| wrData | input | 8 | Host write byte |
| rdData | output | 8 | Registered host read byte |
| dotCount | input | 9 | Current dot within the line |
| vblankSet | input | 1 | Sets the vertical-blank flag |
| vblankClr | input | 1 | Clears the vertical-blank flag |
| sprZeroHit | input | 1 | Sprite-zero hit flag from the renderer |
| sprOverflow | input | 1 | Sprite overflow flag from the renderer |
| sprAddr | output | 8 | Sprite memory address |
| sprWrEn | output | 1 | Sprite memory write enable |
| sprWrData | output | 8 | Sprite memory write byte |
| sprRdData | input | 8 | Sprite memory read byte |
| vidAddr | output | 14 | Video memory address |
| vidWrEn | output | 1 | Video memory write enable |
| vidWrData | output | 8 | Video memory write byte |
| vidRdData | input | 8 | Video memory read byte |
| bgTableSel | output | 1 | Background tile table select |
| sprTableSel | output | 1 | Sprite tile table select |
| tallSprites | output | 1 | Tall sprite mode |
| extMaster | output | 1 | External master/slave select |
| grayscale | output | 1 | Grayscale display |
| bgLeftShow | output | 1 | Show background in leftmost column |
| sprLeftShow | output | 1 | Show sprites in leftmost column |
| bgShow | output | 1 | Background enable |
| sprShow | output | 1 | Sprite enable |
| emphasis | output | 3 | Colour emphasis bits |
| scrollX | output | 9 | Effective horizontal scroll |
| scrollY | output | 9 | Effective vertical scroll |
| irq | output | 1 | Vertical-blank interrupt |

## Verification
The bench builds the block with its default parameters. These are a 14-bit video pointer, a 9-bit dot counter, a forced-zero span over dots 257 to 320, a wide step of 32, and scroll offsets of 256 and 240. With these values the bench can drive the pointer from 0x3FFF across the wrap to zero. It can place the dot counter on both edges of the sprite pointer span (256, 300, 320, 321). It can also check the full nine-bit effective scroll sums against the requirement constants.

// File: rtl/vpu_regif_pkg.sv
package vpu_regif_pkg;

  typedef enum logic [2:0] {
    SEL_CTRL   = 3'd0,
    SEL_MASK   = 3'd1,
    SEL_STAT   = 3'd2,
    SEL_SPRPTR = 3'd3,
    SEL_SPRDAT = 3'd4,
    SEL_SCROLL = 3'd5,
    SEL_VIDPTR = 3'd6,
    SEL_VIDDAT = 3'd7
  } regSel_e;

  typedef struct packed {
    logic wrCtrl;
    logic wrMask;
    logic wrSprPtr;
    logic wrSprDat;
    logic wrScroll;
    logic wrVidPtr;
    logic wrVidDat;
    logic rdStat;
    logic rdSprDat;
    logic rdVidDat;
    logic rdAny;
  } strobe_t;

endpackage

// File: rtl/vpu_regif_ctrl.sv
module vpu_regif_ctrl
  import vpu_regif_pkg::*;
(
  input  logic [2:0] regSel,
  input  logic       wrEn,
  input  logic       rdEn,
  output strobe_t    stb
);

  logic    rdTake;
  regSel_e sel;

  assign sel    = regSel_e'(regSel);
  assign rdTake = rdEn & ~wrEn;

  always_comb begin
    stb          = '0;
    stb.rdAny    = rdTake;
    if (wrEn) begin
      unique case (sel)
        SEL_CTRL:   stb.wrCtrl   = 1'b1;
        SEL_MASK:   stb.wrMask   = 1'b1;
        SEL_SPRPTR: stb.wrSprPtr = 1'b1;
        SEL_SPRDAT: stb.wrSprDat = 1'b1;
        SEL_SCROLL: stb.wrScroll = 1'b1;
        SEL_VIDPTR: stb.wrVidPtr = 1'b1;
        SEL_VIDDAT: stb.wrVidDat = 1'b1;
        default:    ;
      endcase
    end else if (rdTake) begin
      unique case (sel)
        SEL_STAT:   stb.rdStat   = 1'b1;
        SEL_SPRDAT: stb.rdSprDat = 1'b1;
        SEL_VIDDAT: stb.rdVidDat = 1'b1;
        default:    ;
      endcase
    end
  end

endmodule

// File: rtl/vpu_regif_dp.sv
module vpu_regif_dp
  import vpu_regif_pkg::*;
#(
  parameter int VADDR_W   = 14,
  parameter int DOT_W     = 9,
  parameter int WIN_LO    = 256,
  parameter int WIN_HI    = 320,
  parameter int WIDE_STEP = 32,
  parameter int X_SPAN    = 256,
  parameter int Y_SPAN    = 240,
  parameter int SCROLL_W  = 9
) (
  input  logic                clk,
  input  logic                rstN,
  input  strobe_t             stb,
  input  logic [7:0]          wrData,
  input  logic [DOT_W-1:0]    dotCount,
  input  logic                vblankSet,
  input  logic                vblankClr,
  input  logic                sprZeroHit,
  input  logic                sprOverflow,
  input  logic [7:0]          sprRdData,
  input  logic [7:0]          vidRdData,
  output logic [7:0]          rdData,
  output logic [7:0]          sprAddr,
  output logic                sprWrEn,
  output logic [7:0]          sprWrData,
  output logic [VADDR_W-1:0]  vidAddr,
  output logic                vidWrEn,
  output logic [7:0]          vidWrData,
  output logic [7:0]          ctrlBits,
  output logic [7:0]          maskBits,
  output logic [SCROLL_W-1:0] scrollX,
  output logic [SCROLL_W-1:0] scrollY,
  output logic                irq
);

  localparam logic [VADDR_W-1:0]  STEP_ONE  = VADDR_W'(1);
  localparam logic [VADDR_W-1:0]  STEP_WIDE = VADDR_W'(WIDE_STEP);
  localparam logic [DOT_W-1:0]    DOT_LO    = DOT_W'(WIN_LO);
  localparam logic [DOT_W-1:0]    DOT_HI    = DOT_W'(WIN_HI);
  localparam logic [SCROLL_W-1:0] X_ADD     = SCROLL_W'(X_SPAN);
  localparam logic [SCROLL_W-1:0] Y_ADD     = SCROLL_W'(Y_SPAN);

  logic [7:0]         ctrlQ, maskQ, sprPtrQ, scrollXQ, scrollYQ, readBufQ, rdDataQ;
  logic               vblankQ, toggleQ;
  logic [VADDR_W-1:0] vidPtrQ, vidStep, hiLoad, loLoad;
  logic               inWindow;
  logic [7:0]         statusByte, rdMux;

  assign inWindow   = (dotCount > DOT_LO) && (dotCount <= DOT_HI);
  assign vidStep    = ctrlQ[2] ? STEP_WIDE : STEP_ONE;
  assign hiLoad     = VADDR_W'({wrData, 8'h00});
  assign loLoad     = VADDR_W'(wrData);
  assign statusByte = {vblankQ, sprZeroHit, sprOverflow, 5'b00000};

  always_comb begin
    rdMux = 8'h00;
    if (stb.rdStat)        rdMux = statusByte;
    else if (stb.rdSprDat) rdMux = sprRdData;
    else if (stb.rdVidDat) rdMux = readBufQ;
  end

  // host-visible register state
  always_ff @(posedge clk) begin
    if (!rstN) begin
      ctrlQ    <= '0;
      maskQ    <= '0;
      scrollXQ <= '0;
      scrollYQ <= '0;
      toggleQ  <= 1'b0;
      vblankQ  <= 1'b0;
      rdDataQ  <= '0;
    end else begin
      if (stb.wrCtrl) ctrlQ <= wrData;
      if (stb.wrMask) maskQ <= wrData;
      if (stb.wrScroll) begin
        if (!toggleQ) scrollXQ <= wrData;
        else          scrollYQ <= wrData;
      end
      if (stb.rdStat)                        toggleQ <= 1'b0;
      else if (stb.wrScroll || stb.wrVidPtr) toggleQ <= ~toggleQ;
      if (vblankSet)                     vblankQ <= 1'b1;
      else if (vblankClr || stb.rdStat)  vblankQ <= 1'b0;
      if (stb.rdAny) rdDataQ <= rdMux;
    end
  end

  // memory pointers and read buffer
  always_ff @(posedge clk) begin
    if (!rstN) begin
      vidPtrQ  <= '0;
      sprPtrQ  <= '0;
      readBufQ <= '0;
    end else begin
      if (stb.wrVidPtr) begin
        if (!toggleQ) vidPtrQ <= hiLoad;
        else          vidPtrQ <= vidPtrQ | loLoad;
      end else if (stb.wrVidDat || stb.rdVidDat) begin
        vidPtrQ <= vidPtrQ + vidStep;
      end
      if (stb.rdVidDat) readBufQ <= vidRdData;
      if (inWindow)          sprPtrQ <= '0;
      else if (stb.wrSprPtr) sprPtrQ <= wrData;
      else if (stb.wrSprDat) sprPtrQ <= sprPtrQ + 8'd1;
    end
  end

  assign rdData    = rdDataQ;
  assign sprAddr   = sprPtrQ;
  assign sprWrEn   = stb.wrSprDat;
  assign sprWrData = wrData;
  assign vidAddr   = vidPtrQ;
  assign vidWrEn   = stb.wrVidDat;
  assign vidWrData = wrData;
  assign ctrlBits  = ctrlQ;
  assign maskBits  = maskQ;
  assign scrollX   = SCROLL_W'(scrollXQ) + (ctrlQ[0] ? X_ADD : '0);
  assign scrollY   = SCROLL_W'(scrollYQ) + (ctrlQ[1] ? Y_ADD : '0);
  assign irq       = vblankQ & ctrlQ[7];

endmodule

// File: rtl/vpu_regif.sv
module vpu_regif
  import vpu_regif_pkg::*;
#(
  parameter int VADDR_W   = 14,
  parameter int DOT_W     = 9,
  parameter int WIN_LO    = 256,
  parameter int WIN_HI    = 320,
  parameter int WIDE_STEP = 32,
  parameter int X_SPAN    = 256,
  parameter int Y_SPAN    = 240,
  parameter int SCROLL_W  = 9
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic [2:0]          regSel,
  input  logic                wrEn,
  input  logic                rdEn,
  input  logic [7:0]          wrData,
  output logic [7:0]          rdData,
  input  logic [DOT_W-1:0]    dotCount,
  input  logic                vblankSet,
  input  logic                vblankClr,
  input  logic                sprZeroHit,
  input  logic                sprOverflow,
  output logic [7:0]          sprAddr,
  output logic                sprWrEn,
  output logic [7:0]          sprWrData,
  input  logic [7:0]          sprRdData,
  output logic [VADDR_W-1:0]  vidAddr,
  output logic                vidWrEn,
  output logic [7:0]          vidWrData,
  input  logic [7:0]          vidRdData,
  output logic                bgTableSel,
  output logic                sprTableSel,
  output logic                tallSprites,
  output logic                extMaster,
  output logic                grayscale,
  output logic                bgLeftShow,
  output logic                sprLeftShow,
  output logic                bgShow,
  output logic                sprShow,
  output logic [2:0]          emphasis,
  output logic [SCROLL_W-1:0] scrollX,
  output logic [SCROLL_W-1:0] scrollY,
  output logic                irq
);

  strobe_t    stb;
  logic [7:0] ctrlBits, maskBits;
  logic       incWide, irqEnable;

  vpu_regif_ctrl u_ctrl (
    .regSel (regSel),
    .wrEn   (wrEn),
    .rdEn   (rdEn),
    .stb    (stb)
  );

  vpu_regif_dp #(
    .VADDR_W   (VADDR_W),
    .DOT_W     (DOT_W),
    .WIN_LO    (WIN_LO),
    .WIN_HI    (WIN_HI),
    .WIDE_STEP (WIDE_STEP),
    .X_SPAN    (X_SPAN),
    .Y_SPAN    (Y_SPAN),
    .SCROLL_W  (SCROLL_W)
  ) u_dp (
    .clk         (clk),
    .rstN        (rstN),
    .stb         (stb),
    .wrData      (wrData),
    .dotCount    (dotCount),
    .vblankSet   (vblankSet),
    .vblankClr   (vblankClr),
    .sprZeroHit  (sprZeroHit),
    .sprOverflow (sprOverflow),
    .sprRdData   (sprRdData),
    .vidRdData   (vidRdData),
    .rdData      (rdData),
    .sprAddr     (sprAddr),
    .sprWrEn     (sprWrEn),
    .sprWrData   (sprWrData),
    .vidAddr     (vidAddr),
    .vidWrEn     (vidWrEn),
    .vidWrData   (vidWrData),
    .ctrlBits    (ctrlBits),
    .maskBits    (maskBits),
    .scrollX     (scrollX),
    .scrollY     (scrollY),
    .irq         (irq)
  );

  assign incWide     = ctrlBits[2];
  assign sprTableSel = ctrlBits[3];
  assign bgTableSel  = ctrlBits[4];
  assign tallSprites = ctrlBits[5];
  assign extMaster   = ctrlBits[6];
  assign irqEnable   = ctrlBits[7];
  assign grayscale   = maskBits[0];
  assign bgLeftShow  = maskBits[1];
  assign sprLeftShow = maskBits[2];
  assign bgShow      = maskBits[3];
  assign sprShow     = maskBits[4];
  assign emphasis    = maskBits[7:5];

endmodule

// File: rtl/vpu_regif_chk.sv
module vpu_regif_chk #(
  parameter int VADDR_W = 14,
  parameter int DOT_W   = 9,
  parameter int WIN_LO  = 256,
  parameter int WIN_HI  = 320
) (
  input logic               clk,
  input logic               rstN,
  input logic [2:0]         regSel,
  input logic               wrEn,
  input logic               rdEn,
  input logic [DOT_W-1:0]   dotCount,
  input logic               vblankSet,
  input logic [7:0]         sprAddr,
  input logic               sprWrEn,
  input logic [VADDR_W-1:0] vidAddr,
  input logic               vidWrEn,
  input logic               incWide,
  input logic               irqEnable,
  input logic               irq
);

  logic dotIn;
  assign dotIn = (int'(dotCount) > WIN_LO) && (int'(dotCount) <= WIN_HI);

  AST_SPR_PARK: assert property (@(posedge clk) disable iff (!rstN)
    dotIn |=> (sprAddr == 8'd0)); // R12

  AST_IRQ_RISE: assert property (@(posedge clk) disable iff (!rstN)
    (vblankSet && irqEnable) |=> irq); // R13

  AST_STAT_DROP: assert property (@(posedge clk) disable iff (!rstN)
    (rdEn && !wrEn && regSel == 3'd2 && !vblankSet) |=> !irq); // R4

  AST_NO_STRAY_WR: assert property (@(posedge clk) disable iff (!rstN)
    !wrEn |-> (!vidWrEn && !sprWrEn)); // R14

  AST_VID_STEP: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && regSel == 3'd7 && !incWide) |=> (vidAddr == VADDR_W'($past(vidAddr) + 1'b1))); // R9

  AST_SPR_RD_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    (rdEn && !wrEn && regSel == 3'd4 && !dotIn) |=> $stable(sprAddr)); // R11

endmodule

bind vpu_regif vpu_regif_chk #(
  .VADDR_W (VADDR_W),
  .DOT_W   (DOT_W),
  .WIN_LO  (WIN_LO),
  .WIN_HI  (WIN_HI)
) u_chk (
  .clk       (clk),
  .rstN      (rstN),
  .regSel    (regSel),
  .wrEn      (wrEn),
  .rdEn      (rdEn),
  .dotCount  (dotCount),
  .vblankSet (vblankSet),
  .sprAddr   (sprAddr),
  .sprWrEn   (sprWrEn),
  .vidAddr   (vidAddr),
  .vidWrEn   (vidWrEn),
  .incWide   (incWide),
  .irqEnable (irqEnable),
  .irq       (irq)
);

// File: tb/sim_vpu_regif.sv
module sim_vpu_regif;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [2:0]  regSel = '0;
  logic        wrEn = 1'b0, rdEn = 1'b0;
  logic [7:0]  wrData = '0;
  logic [7:0]  rdData;
  logic [8:0]  dotCount = '0;
  logic        vblankSet = 1'b0, vblankClr = 1'b0;
  logic        sprZeroHit = 1'b0, sprOverflow = 1'b0;
  logic [7:0]  sprAddr, sprWrData, sprRdData;
  logic        sprWrEn;
  logic [13:0] vidAddr;
  logic        vidWrEn;
  logic [7:0]  vidWrData, vidRdData;
  logic        bgTableSel, sprTableSel, tallSprites, extMaster;
  logic        grayscale, bgLeftShow, sprLeftShow, bgShow, sprShow;
  logic [2:0]  emphasis;
  logic [8:0]  scrollX, scrollY;
  logic        irq;

  int total = 0;
  int bad = 0;
  bit finished = 0;

  always #2 clk = ~clk;

  vpu_regif u0 (
    .clk(clk), .rstN(rstN), .regSel(regSel), .wrEn(wrEn), .rdEn(rdEn),
    .wrData(wrData), .rdData(rdData), .dotCount(dotCount),
    .vblankSet(vblankSet), .vblankClr(vblankClr),
    .sprZeroHit(sprZeroHit), .sprOverflow(sprOverflow),
    .sprAddr(sprAddr), .sprWrEn(sprWrEn), .sprWrData(sprWrData), .sprRdData(sprRdData),
    .vidAddr(vidAddr), .vidWrEn(vidWrEn), .vidWrData(vidWrData), .vidRdData(vidRdData),
    .bgTableSel(bgTableSel), .sprTableSel(sprTableSel), .tallSprites(tallSprites),
    .extMaster(extMaster), .grayscale(grayscale), .bgLeftShow(bgLeftShow),
    .sprLeftShow(sprLeftShow), .bgShow(bgShow), .sprShow(sprShow),
    .emphasis(emphasis), .scrollX(scrollX), .scrollY(scrollY), .irq(irq)
  );

  // memory models (video memory folded onto 1024 bytes)
  logic [7:0] smem [0:255];
  logic [7:0] vmem [0:1023];
  assign sprRdData = smem[sprAddr];
  assign vidRdData = vmem[vidAddr[9:0]];
  always @(posedge clk) begin
    if (sprWrEn) smem[sprAddr] <= sprWrData;
    if (vidWrEn) vmem[vidAddr[9:0]] <= vidWrData;
  end

  // scoreboard
  logic [7:0] expQ[$];
  string      tagQ[$];
  logic       rdSeen = 1'b0;

  task automatic check(string tag, int act, int exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
    end
  endtask

  always @(posedge clk) rdSeen <= rdEn & ~wrEn;

  always @(negedge clk) begin
    if (rdSeen) begin
      if (expQ.size() == 0) begin
        check("read-queue-empty", 1, 0);
      end else begin
        logic [7:0] e;
        string t;
        e = expQ.pop_front();
        t = tagQ.pop_front();
        check(t, int'(rdData), int'(e));
      end
    end
  end

  task automatic regWr(input logic [2:0] sel, input logic [7:0] d);
    @(negedge clk);
    regSel = sel; wrData = d; wrEn = 1'b1;
    @(negedge clk);
    wrEn = 1'b0;
  endtask

  task automatic regRd(input logic [2:0] sel, input logic [7:0] e, input string tag);
    @(negedge clk);
    regSel = sel; rdEn = 1'b1;
    expQ.push_back(e);
    tagQ.push_back(tag);
    @(negedge clk);
    rdEn = 1'b0;
  endtask

  task automatic pulseSet();
    @(negedge clk); vblankSet = 1'b1;
    @(negedge clk); vblankSet = 1'b0;
  endtask

  task automatic pulseClr();
    @(negedge clk); vblankClr = 1'b1;
    @(negedge clk); vblankClr = 1'b0;
  endtask

  task automatic finishRun();
    if (!finished) begin
      finished = 1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    check("watchdog", 1, 0);
    finishRun();
  end

  initial begin
    for (int i = 0; i < 256; i++) smem[i] = 8'h00;
    for (int i = 0; i < 1024; i++) vmem[i] = 8'h00;
    vmem[10'h200] = 8'h5A;
    vmem[10'h201] = 8'hC3;

    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    // R1 reset state
    check("R1 rdData", rdData, 0);
    check("R1 sprAddr", sprAddr, 0);
    check("R1 vidAddr", vidAddr, 0);
    check("R1 scroll", {scrollX, scrollY}, 0);
    check("R1 irq", irq, 0);
    check("R1 fields", {bgTableSel, sprTableSel, tallSprites, extMaster, grayscale,
                        bgLeftShow, sprLeftShow, bgShow, sprShow, emphasis}, 0);

    // R2 control decode
    regWr(3'd0, 8'h7C);
    check("R2 fields 7C", {bgTableSel, sprTableSel, tallSprites, extMaster}, 4'b1111);
    regWr(3'd0, 8'h08);
    check("R2 fields 08", {bgTableSel, sprTableSel, tallSprites, extMaster}, 4'b0100);
    regWr(3'd0, 8'h00);

    // R3 mask decode
    regWr(3'd1, 8'hE5);
    check("R3 mask E5", {grayscale, bgLeftShow, sprLeftShow, bgShow, sprShow, emphasis},
          {5'b10100, 3'b111});
    regWr(3'd1, 8'h1A);
    check("R3 mask 1A", {grayscale, bgLeftShow, sprLeftShow, bgShow, sprShow, emphasis},
          {5'b01011, 3'b000});

    // R6 scroll pair
    regWr(3'd5, 8'h12);
    regWr(3'd5, 8'h34);
    check("R6 scrollX", scrollX, 9'h012);
    check("R6 scrollY", scrollY, 9'h034);

    // R7 nametable offsets
    regWr(3'd0, 8'h03);
    check("R7 scrollX+256", scrollX, 9'h112);
    check("R7 scrollY+240", scrollY, 9'h124);
    regWr(3'd0, 8'h00);

    // R5 status read resets toggle
    regWr(3'd5, 8'h55);
    regRd(3'd2, 8'h00, "R5 status idle");
    regWr(3'd5, 8'h66);
    check("R5 toggle reset X", scrollX, 9'h066);
    check("R5 toggle reset Y", scrollY, 9'h034);

    // R4 status bits and vblank clear
    sprZeroHit = 1'b1; sprOverflow = 1'b1;
    pulseSet();
    regRd(3'd2, 8'hE0, "R4 status set");
    regRd(3'd2, 8'h60, "R4 status cleared");
    sprZeroHit = 1'b0; sprOverflow = 1'b0;

    // R8 video pointer
    regWr(3'd6, 8'h12);
    regWr(3'd6, 8'h34);
    check("R8 pointer 1234", vidAddr, 14'h1234);
    regWr(3'd6, 8'hFF);
    check("R8 high masked", vidAddr, 14'h3F00);
    regWr(3'd6, 8'hFF);
    check("R8 pointer 3FFF", vidAddr, 14'h3FFF);

    // R9 data write, step and wrap
    regWr(3'd7, 8'hAB);
    check("R9 wrap", vidAddr, 14'h0000);
    check("R9 stored", vmem[10'h3FF], 8'hAB);
    regWr(3'd0, 8'h04);
    regWr(3'd6, 8'h00);
    regWr(3'd6, 8'h10);
    regWr(3'd7, 8'h11);
    check("R9 step 32", vidAddr, 14'h0030);
    check("R9 stored 32", vmem[10'h010], 8'h11);
    regWr(3'd0, 8'h00);

    // R10 buffered data read
    regWr(3'd6, 8'h02);
    regWr(3'd6, 8'h00);
    regRd(3'd7, 8'h00, "R10 first read stale");
    regRd(3'd7, 8'h5A, "R10 second read");
    regRd(3'd7, 8'hC3, "R10 third read");
    check("R10 pointer", vidAddr, 14'h0203);

    // R11 sprite pointer and data
    regWr(3'd3, 8'h10);
    regWr(3'd4, 8'h77);
    regWr(3'd4, 8'h88);
    check("R11 post-inc", sprAddr, 8'h12);
    check("R11 stored", {smem[8'h10], smem[8'h11]}, 16'h7788);
    regWr(3'd3, 8'h11);
    regRd(3'd4, 8'h88, "R11 sprite read");
    check("R11 read no inc", sprAddr, 8'h11);

    // R12 dot window
    regWr(3'd3, 8'h40);
    @(negedge clk); dotCount = 9'd300;
    @(negedge clk);
    check("R12 inside 300", sprAddr, 8'h00);
    dotCount = 9'd256;
    regWr(3'd3, 8'h40);
    @(negedge clk);
    check("R12 edge 256", sprAddr, 8'h40);
    dotCount = 9'd320;
    @(negedge clk);
    check("R12 edge 320", sprAddr, 8'h00);
    dotCount = 9'd321;
    regWr(3'd3, 8'h41);
    check("R12 edge 321", sprAddr, 8'h41);
    dotCount = 9'd0;

    // R13 interrupt
    regWr(3'd0, 8'h80);
    check("R13 idle", irq, 0);
    pulseSet();
    check("R13 raised", irq, 1);
    pulseClr();
    check("R13 cleared", irq, 0);
    regWr(3'd0, 8'h00);
    pulseSet();
    check("R13 masked", irq, 0);
    regWr(3'd0, 8'h80);
    check("R13 late enable", irq, 1);
    regRd(3'd2, 8'h80, "R13 status");
    check("R13 read drop", irq, 0);
    regWr(3'd0, 8'h7C);

    // R14 ignored status write, zero reads
    regWr(3'd5, 8'h21);
    regWr(3'd2, 8'hFF);
    regWr(3'd5, 8'h43);
    check("R14 toggle kept X", scrollX, 9'h021);
    check("R14 toggle kept Y", scrollY, 9'h043);
    regRd(3'd2, 8'h00, "R14 status unchanged");
    regRd(3'd0, 8'h00, "R14 read ctrl zero");
    regRd(3'd1, 8'h00, "R14 read mask zero");
    regRd(3'd3, 8'h00, "R14 read sprptr zero");
    regRd(3'd5, 8'h00, "R14 read scroll zero");
    regRd(3'd6, 8'h00, "R14 read vidptr zero");

    repeat (4) @(negedge clk);
    check("scoreboard drained", expQ.size(), 0);
    finishRun();
  end

endmodule